// File: doc/BRIEF.md
# Polyphase Scaler Position Generator

This block walks the destination grid of a two-dimensional image resampler and, for every output pixel, works out where in the source image the polyphase filter must sample. It has two independent channels, one for luma and one for chroma. Each channel keeps a horizontal and a vertical fixed-point position with 13 fractional bits. A channel is loaded with a signed start offset and advances by an unsigned increment per output pixel (horizontal) or per output line (vertical). From each position the block emits an integer source sample index and a 4-bit filter phase. With every beat it also marks the first pixel of a line, the last pixel of a line and the last pixel of a frame.

Software computes the increments as the rounded ratio `((src << 13) + dst/2) / dst` and writes them, together with the start offsets and the sizes. Chroma gets its own sizes and starts, so sub-sampled chroma can be re-sited against luma. Typical values are a vertical start of -2048 (a quarter line up) or -4096 (half a line up) for 4:2:0 sources, and a horizontal start of -2048 for chroma that sits a quarter sample to the right. Software also follows these rules: it halves the chroma source width for 4:2:2 and 4:2:0 input and the chroma source height for 4:2:0 only, it halves the chroma destination width for 4:2:2 output, and it programs a source height one line short when 4:4:4 input becomes 4:2:2 output. A single `frame_go` pulse starts both channels. Each channel then streams its beats to the downstream filter over its own valid/ready handshake.

Top module: `psc_pos_gen`

## Requirements
- R1: After reset neither channel asserts valid until `frame_go` is seen. Valid rises on the clock edge that samples `frame_go` high while the channel is idle.
- R2: While a channel's valid is high and its ready is low, every output of that channel holds its value.
- R3: For pixel n (counted from 0) of an output line, the horizontal position is hstart + n·hinc, read as a two's complement number with 13 fractional bits. The index is the integer part and the phase is fraction bits [12:9].
- R4: The horizontal position reloads hstart at the start of every output line. The vertical position starts at vstart for the frame and grows by vinc once per completed output line, so line m uses vstart + m·vinc.
- R5: A frame has exactly W·H accepted beats, where W and H are the destination width and height. Line start is high on pixel 0 of each line, line end is high on pixel W-1, and frame end is high only on the last pixel of line H-1. Valid is low on the cycle after the frame-end beat is accepted.
- R6: A negative position is clamped to index 0 with phase 0.
- R7: A position whose integer part is larger than the last source sample is clamped to that last sample with phase 0. Width-1 bounds the horizontal direction and height-1 bounds the vertical direction.
- R8: The chroma channel uses only its own sizes, starts, increments and ready, so luma and chroma run independently from the same `frame_go`.
- R9: A `frame_go` pulse that arrives while a channel is running a frame does not restart or disturb it.
- R10: A size register holds width-1 in bits 11:0 and height-1 in bits 27:16, and its other bits are ignored. The horizontal start is a 19-bit and the vertical start a 16-bit two's complement value. Both increments are 16-bit unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Pulse that starts a frame on idle channels |
| l_src_res | input | 32 | Luma source size register (width-1, height-1) |
| l_dst_res | input | 32 | Luma destination size register |
| l_hstart | input | 19 | Luma horizontal start, signed, 13 fraction bits |
| l_vstart | input | 16 | Luma vertical start, signed, 13 fraction bits |
| l_hinc | input | 16 | Luma horizontal increment |
| l_vinc | input | 16 | Luma vertical increment |
| l_rdy | input | 1 | Downstream ready for luma beats |
| l_vld | output | 1 | Luma beat valid |
| l_x_idx | output | 12 | Luma horizontal source index |
| l_x_ph | output | 4 | Luma horizontal phase |
| l_y_idx | output | 12 | Luma vertical source index |
| l_y_ph | output | 4 | Luma vertical phase |
| l_sol | output | 1 | Luma first pixel of line |
| l_eol | output | 1 | Luma last pixel of line |
| l_eof | output | 1 | Luma last pixel of frame |
| c_src_res | input | 32 | Chroma source size register |
| c_dst_res | input | 32 | Chroma destination size register |
| c_hstart | input | 19 | Chroma horizontal start |
| c_vstart | input | 16 | Chroma vertical start |
| c_hinc | input | 16 | Chroma horizontal increment |
| c_vinc | input | 16 | Chroma vertical increment |
| c_rdy | input | 1 | Downstream ready for chroma beats |
| c_vld | output | 1 | Chroma beat valid |
| c_x_idx | output | 12 | Chroma horizontal source index |
| c_x_ph | output | 4 | Chroma horizontal phase |
| c_y_idx | output | 12 | Chroma vertical source index |
| c_y_ph | output | 4 | Chroma vertical phase |
| c_sol | output | 1 | Chroma first pixel of line |
| c_eol | output | 1 | Chroma last pixel of line |
| c_eof | output | 1 | Chroma last pixel of frame |

## Verification
Valid rises on the first rising edge after `frame_go` is driven. After each accepted beat, the next beat's index, phase and markers appear on the very next rising edge, because the outputs are decoded straight from the position registers without a further stage. The bench changes ready and `frame_go` on the falling edge and reads the outputs on that same falling edge. Any beat it sees with valid and ready both high is therefore the one taken at the next rising edge, and it compares that beat with positions it computes itself from start + n·increment. Any beat seen stalled is compared against the same channel's outputs one falling edge later.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int PSC_FRAC_W     = 13;
  localparam int PSC_PHASE_W    = 4;
  localparam int PSC_RES_W      = 12;
  localparam int PSC_INC_W      = 16;
  localparam int PSC_HSTART_W   = 19;
  localparam int PSC_VSTART_W   = 16;
  localparam int PSC_REG_W      = 32;
  localparam int PSC_HEIGHT_LSB = 16;

  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;
endpackage

// File: rtl/psc_axis.sv
// One fixed-point position accumulator with index/phase decode and clamping.
module psc_axis #(
  parameter int START_W = 16,
  parameter int INC_W   = 16,
  parameter int RES_W   = 12,
  parameter int FRAC_W  = 13,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [START_W-1:0] start,
  input  logic [INC_W-1:0]   inc,
  input  logic [RES_W-1:0]   last,
  output logic [RES_W-1:0]   idx,
  output logic [PHASE_W-1:0] ph
);
  localparam int SPAN_W = RES_W + INC_W + 2;
  localparam int ACC_W  = (SPAN_W > START_W + 1) ? SPAN_W : START_W + 1;
  localparam int PAD_W  = ACC_W - RES_W - 1 - FRAC_W;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] limit;
  logic                    below;
  logic                    beyond;

  // first position past the last valid source sample
  function automatic logic signed [ACC_W-1:0] edge_pos(input logic [RES_W-1:0] l);
    return {{PAD_W{1'b0}}, ({1'b0, l} + (RES_W+1)'(1)), {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [RES_W-1:0] pick_index(input logic signed [ACC_W-1:0] a,
                                                  input logic lo, input logic hi,
                                                  input logic [RES_W-1:0] l);
    if (lo)      return '0;
    else if (hi) return l;
    else         return a[FRAC_W +: RES_W];
  endfunction

  function automatic logic [PHASE_W-1:0] pick_phase(input logic signed [ACC_W-1:0] a,
                                                    input logic lo, input logic hi);
    if (lo || hi) return '0;
    else          return a[FRAC_W-1 -: PHASE_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (load) begin
      acc <= {{(ACC_W-START_W){start[START_W-1]}}, start};
    end else if (step) begin
      acc <= acc + $signed({{(ACC_W-INC_W){1'b0}}, inc});
    end
  end

  assign limit  = edge_pos(last);
  assign below  = acc[ACC_W-1];
  assign beyond = !below && (acc >= limit);
  assign idx    = pick_index(acc, below, beyond, last);
  assign ph     = pick_phase(acc, below, beyond);
endmodule

// File: rtl/psc_channel.sv
// One colour channel: destination grid walker plus horizontal and vertical axes.
module psc_channel
  import psc_pkg::*;
#(
  parameter int HSTART_W   = PSC_HSTART_W,
  parameter int VSTART_W   = PSC_VSTART_W,
  parameter int INC_W      = PSC_INC_W,
  parameter int RES_W      = PSC_RES_W,
  parameter int FRAC_W     = PSC_FRAC_W,
  parameter int PHASE_W    = PSC_PHASE_W,
  parameter int REG_W      = PSC_REG_W,
  parameter int HEIGHT_LSB = PSC_HEIGHT_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [REG_W-1:0]    src_res,
  input  logic [REG_W-1:0]    dst_res,
  input  logic [HSTART_W-1:0] hstart,
  input  logic [VSTART_W-1:0] vstart,
  input  logic [INC_W-1:0]    hinc,
  input  logic [INC_W-1:0]    vinc,
  input  logic                rdy,
  output logic                vld,
  output logic [RES_W-1:0]    x_idx,
  output logic [PHASE_W-1:0]  x_ph,
  output logic [RES_W-1:0]    y_idx,
  output logic [PHASE_W-1:0]  y_ph,
  output logic                sol,
  output logic                eol,
  output logic                eof
);
  ch_state_e        state;
  logic [RES_W-1:0] ox;
  logic [RES_W-1:0] oy;
  logic [RES_W-1:0] dw_last, dh_last, sw_last, sh_last;
  logic             start_frame;
  logic             fire;
  logic             at_eol;
  logic             at_eof;
  logic             unused_fields;

  assign dw_last = dst_res[RES_W-1:0];
  assign dh_last = dst_res[HEIGHT_LSB +: RES_W];
  assign sw_last = src_res[RES_W-1:0];
  assign sh_last = src_res[HEIGHT_LSB +: RES_W];
  assign unused_fields = ^{src_res[REG_W-1:HEIGHT_LSB+RES_W], src_res[HEIGHT_LSB-1:RES_W],
                           dst_res[REG_W-1:HEIGHT_LSB+RES_W], dst_res[HEIGHT_LSB-1:RES_W]};

  assign start_frame = go && (state == CH_IDLE);
  assign fire        = (state == CH_RUN) && rdy;
  assign at_eol      = (ox == dw_last);
  assign at_eof      = at_eol && (oy == dh_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CH_IDLE;
      ox    <= '0;
      oy    <= '0;
    end else if (start_frame) begin
      state <= CH_RUN;
      ox    <= '0;
      oy    <= '0;
    end else if (fire) begin
      if (at_eol) begin
        ox <= '0;
        if (at_eof) state <= CH_IDLE;
        else        oy    <= oy + RES_W'(1);
      end else begin
        ox <= ox + RES_W'(1);
      end
    end
  end

  psc_axis #(
    .START_W(HSTART_W), .INC_W(INC_W), .RES_W(RES_W),
    .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)
  ) u_hax (
    .clk(clk), .rst_n(rst_n),
    .load(start_frame || (fire && at_eol)),
    .step(fire && !at_eol),
    .start(hstart), .inc(hinc), .last(sw_last),
    .idx(x_idx), .ph(x_ph)
  );

  psc_axis #(
    .START_W(VSTART_W), .INC_W(INC_W), .RES_W(RES_W),
    .FRAC_W(FRAC_W), .PHASE_W(PHASE_W)
  ) u_vax (
    .clk(clk), .rst_n(rst_n),
    .load(start_frame),
    .step(fire && at_eol && !at_eof),
    .start(vstart), .inc(vinc), .last(sh_last),
    .idx(y_idx), .ph(y_ph)
  );

  assign vld = (state == CH_RUN);
  assign sol = (ox == '0);
  assign eol = at_eol;
  assign eof = at_eof;
endmodule

// File: rtl/psc_pos_gen.sv
// Top: independent luma and chroma position channels started by one pulse.
module psc_pos_gen
  import psc_pkg::*;
#(
  parameter int FRAC_W     = PSC_FRAC_W,
  parameter int PHASE_W    = PSC_PHASE_W,
  parameter int RES_W      = PSC_RES_W,
  parameter int INC_W      = PSC_INC_W,
  parameter int HSTART_W   = PSC_HSTART_W,
  parameter int VSTART_W   = PSC_VSTART_W,
  parameter int REG_W      = PSC_REG_W,
  parameter int HEIGHT_LSB = PSC_HEIGHT_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_go,
  input  logic [REG_W-1:0]    l_src_res,
  input  logic [REG_W-1:0]    l_dst_res,
  input  logic [HSTART_W-1:0] l_hstart,
  input  logic [VSTART_W-1:0] l_vstart,
  input  logic [INC_W-1:0]    l_hinc,
  input  logic [INC_W-1:0]    l_vinc,
  input  logic                l_rdy,
  output logic                l_vld,
  output logic [RES_W-1:0]    l_x_idx,
  output logic [PHASE_W-1:0]  l_x_ph,
  output logic [RES_W-1:0]    l_y_idx,
  output logic [PHASE_W-1:0]  l_y_ph,
  output logic                l_sol,
  output logic                l_eol,
  output logic                l_eof,
  input  logic [REG_W-1:0]    c_src_res,
  input  logic [REG_W-1:0]    c_dst_res,
  input  logic [HSTART_W-1:0] c_hstart,
  input  logic [VSTART_W-1:0] c_vstart,
  input  logic [INC_W-1:0]    c_hinc,
  input  logic [INC_W-1:0]    c_vinc,
  input  logic                c_rdy,
  output logic                c_vld,
  output logic [RES_W-1:0]    c_x_idx,
  output logic [PHASE_W-1:0]  c_x_ph,
  output logic [RES_W-1:0]    c_y_idx,
  output logic [PHASE_W-1:0]  c_y_ph,
  output logic                c_sol,
  output logic                c_eol,
  output logic                c_eof
);
  psc_channel #(
    .HSTART_W(HSTART_W), .VSTART_W(VSTART_W), .INC_W(INC_W), .RES_W(RES_W),
    .FRAC_W(FRAC_W), .PHASE_W(PHASE_W), .REG_W(REG_W), .HEIGHT_LSB(HEIGHT_LSB)
  ) u_luma (
    .clk(clk), .rst_n(rst_n), .go(frame_go),
    .src_res(l_src_res), .dst_res(l_dst_res),
    .hstart(l_hstart), .vstart(l_vstart), .hinc(l_hinc), .vinc(l_vinc),
    .rdy(l_rdy), .vld(l_vld),
    .x_idx(l_x_idx), .x_ph(l_x_ph), .y_idx(l_y_idx), .y_ph(l_y_ph),
    .sol(l_sol), .eol(l_eol), .eof(l_eof)
  );

  psc_channel #(
    .HSTART_W(HSTART_W), .VSTART_W(VSTART_W), .INC_W(INC_W), .RES_W(RES_W),
    .FRAC_W(FRAC_W), .PHASE_W(PHASE_W), .REG_W(REG_W), .HEIGHT_LSB(HEIGHT_LSB)
  ) u_chroma (
    .clk(clk), .rst_n(rst_n), .go(frame_go),
    .src_res(c_src_res), .dst_res(c_dst_res),
    .hstart(c_hstart), .vstart(c_vstart), .hinc(c_hinc), .vinc(c_vinc),
    .rdy(c_rdy), .vld(c_vld),
    .x_idx(c_x_idx), .x_ph(c_x_ph), .y_idx(c_y_idx), .y_ph(c_y_ph),
    .sol(c_sol), .eol(c_eol), .eof(c_eof)
  );
endmodule

// File: rtl/psc_pos_gen_chk.sv
// Protocol and bound checks on the ports of psc_pos_gen.
module psc_pos_gen_chk #(
  parameter int RES_W   = 12,
  parameter int PHASE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_go,
  input logic [RES_W-1:0]   l_sw_last,
  input logic [RES_W-1:0]   l_sh_last,
  input logic               l_rdy,
  input logic               l_vld,
  input logic [RES_W-1:0]   l_x_idx,
  input logic [PHASE_W-1:0] l_x_ph,
  input logic [RES_W-1:0]   l_y_idx,
  input logic [PHASE_W-1:0] l_y_ph,
  input logic               l_sol,
  input logic               l_eol,
  input logic               l_eof,
  input logic [RES_W-1:0]   c_sw_last,
  input logic [RES_W-1:0]   c_sh_last,
  input logic               c_rdy,
  input logic               c_vld,
  input logic [RES_W-1:0]   c_x_idx,
  input logic [PHASE_W-1:0] c_x_ph,
  input logic [RES_W-1:0]   c_y_idx,
  input logic [PHASE_W-1:0] c_y_ph,
  input logic               c_sol,
  input logic               c_eol,
  input logic               c_eof
);
  // R1
  idle_until_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_vld && !frame_go) |=> !l_vld);

  // R2
  l_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_vld && !l_rdy) |=> (l_vld && $stable(l_x_idx) && $stable(l_x_ph) &&
      $stable(l_y_idx) && $stable(l_y_ph) && $stable(l_sol) && $stable(l_eol) && $stable(l_eof)));

  // R2
  c_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vld && !c_rdy) |=> (c_vld && $stable(c_x_idx) && $stable(c_x_ph) &&
      $stable(c_y_idx) && $stable(c_y_ph) && $stable(c_sol) && $stable(c_eol) && $stable(c_eof)));

  // R3
  l_x_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_vld && l_rdy && !l_eol) |=> (l_vld && l_x_idx >= $past(l_x_idx)));

  // R5
  l_eof_on_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_vld && l_eof) |-> l_eol);

  // R5
  c_eof_on_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vld && c_eof) |-> c_eol);

  // R5
  l_new_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_vld && l_rdy && l_eol && !l_eof) |=> (l_vld && l_sol));

  // R5
  l_frame_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_vld && l_rdy && l_eof) |=> !l_vld);

  // R5
  c_frame_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_vld && c_rdy && c_eof) |=> !c_vld);

  // R7
  l_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_vld |-> (l_x_idx <= l_sw_last && l_y_idx <= l_sh_last));

  // R7
  c_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |-> (c_x_idx <= c_sw_last && c_y_idx <= c_sh_last));
endmodule

bind psc_pos_gen psc_pos_gen_chk #(.RES_W(RES_W), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_go(frame_go),
  .l_sw_last(l_src_res[RES_W-1:0]), .l_sh_last(l_src_res[HEIGHT_LSB +: RES_W]),
  .l_rdy(l_rdy), .l_vld(l_vld), .l_x_idx(l_x_idx), .l_x_ph(l_x_ph),
  .l_y_idx(l_y_idx), .l_y_ph(l_y_ph), .l_sol(l_sol), .l_eol(l_eol), .l_eof(l_eof),
  .c_sw_last(c_src_res[RES_W-1:0]), .c_sh_last(c_src_res[HEIGHT_LSB +: RES_W]),
  .c_rdy(c_rdy), .c_vld(c_vld), .c_x_idx(c_x_idx), .c_x_ph(c_x_ph),
  .c_y_idx(c_y_idx), .c_y_ph(c_y_ph), .c_sol(c_sol), .c_eol(c_eol), .c_eof(c_eof)
);

// File: tb/sim_psc_pos_gen.sv
module sim_psc_pos_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;

  typedef struct packed {
    logic [11:0]        sw;
    logic [11:0]        sh;
    logic [11:0]        dw;
    logic [11:0]        dh;
    logic signed [18:0] hs;
    logic signed [15:0] vs;
  } axcfg_t;

  // true sizes (not minus one); increments are derived below
  localparam axcfg_t LV [NVEC] = '{
    '{12'd8,  12'd4,  12'd8, 12'd4,  19'sd0,       16'sd0},
    '{12'd20, 12'd10, 12'd6, 12'd4,  19'sd0,       16'sd0},
    '{12'd3,  12'd3,  12'd7, 12'd5,  19'sd20000,   16'sd30000},
    '{12'd5,  12'd5,  12'd1, 12'd1, -19'sd100000,  16'sd0}
  };
  localparam axcfg_t CV [NVEC] = '{
    '{12'd4,  12'd2,  12'd8, 12'd4,  19'sd0,      -16'sd2048},
    '{12'd10, 12'd10, 12'd6, 12'd4, -19'sd2048,    16'sd0},
    '{12'd2,  12'd2,  12'd4, 12'd3,  19'sd0,       16'sd0},
    '{12'd4,  12'd3,  12'd1, 12'd1,  19'sd0,      -16'sd4096}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic frame_go;
  logic [31:0] l_src_res, l_dst_res, c_src_res, c_dst_res;
  logic [18:0] l_hstart, c_hstart;
  logic [15:0] l_vstart, c_vstart, l_hinc, l_vinc, c_hinc, c_vinc;
  logic l_rdy, c_rdy;
  logic l_vld, l_sol, l_eol, l_eof, c_vld, c_sol, c_eol, c_eof;
  logic [11:0] l_x_idx, l_y_idx, c_x_idx, c_y_idx;
  logic [3:0]  l_x_ph, l_y_ph, c_x_ph, c_y_ph;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psc_pos_gen u0 (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go),
    .l_src_res(l_src_res), .l_dst_res(l_dst_res), .l_hstart(l_hstart), .l_vstart(l_vstart),
    .l_hinc(l_hinc), .l_vinc(l_vinc), .l_rdy(l_rdy), .l_vld(l_vld),
    .l_x_idx(l_x_idx), .l_x_ph(l_x_ph), .l_y_idx(l_y_idx), .l_y_ph(l_y_ph),
    .l_sol(l_sol), .l_eol(l_eol), .l_eof(l_eof),
    .c_src_res(c_src_res), .c_dst_res(c_dst_res), .c_hstart(c_hstart), .c_vstart(c_vstart),
    .c_hinc(c_hinc), .c_vinc(c_vinc), .c_rdy(c_rdy), .c_vld(c_vld),
    .c_x_idx(c_x_idx), .c_x_ph(c_x_ph), .c_y_idx(c_y_idx), .c_y_ph(c_y_ph),
    .c_sol(c_sol), .c_eol(c_eol), .c_eof(c_eof)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R10: width-1 in bits 11:0, height-1 in bits 27:16; bits 15:12 and 31:28 set to prove they are ignored
  function automatic logic [31:0] pack_res(input int w, input int h);
    return 32'hF000_F000 | (32'(h - 1) << 16) | 32'(w - 1);
  endfunction

  function automatic int rinc(input int s, input int d);
    return ((s << 13) + d / 2) / d;
  endfunction

  function automatic int exp_idx(input int pos, input int last);
    if (pos < 0) return 0;
    if ((pos >>> 13) > last) return last;
    return pos >>> 13;
  endfunction

  function automatic int exp_ph(input int pos, input int last);
    if (pos < 0 || (pos >>> 13) > last) return 0;
    return (pos >>> 9) & 15;
  endfunction

  function automatic string tag_of(input int pos, input int last, input string dflt);
    if (pos < 0) return "R6";
    if ((pos >>> 13) > last) return "R7";
    return dflt;
  endfunction

  task automatic beat(input string ch, input axcfg_t c, input int x, input int y,
                      input int axi, input int axp, input int ayi, input int ayp,
                      input bit asol, input bit aeol, input bit aeof);
    int hp = int'(c.hs) + x * rinc(c.sw, c.dw);
    int vp = int'(c.vs) + y * rinc(c.sh, c.dh);
    string th = tag_of(hp, c.sw - 1, (ch == "chroma") ? "R8 R3" : "R3");
    string tv = tag_of(vp, c.sh - 1, (ch == "chroma") ? "R8 R4" : "R4");
    chk(axi == exp_idx(hp, c.sw - 1), th, {ch, " x_idx"}, axi, exp_idx(hp, c.sw - 1));
    chk(axp == exp_ph(hp, c.sw - 1),  th, {ch, " x_ph"},  axp, exp_ph(hp, c.sw - 1));
    chk(ayi == exp_idx(vp, c.sh - 1), tv, {ch, " y_idx"}, ayi, exp_idx(vp, c.sh - 1));
    chk(ayp == exp_ph(vp, c.sh - 1),  tv, {ch, " y_ph"},  ayp, exp_ph(vp, c.sh - 1));
    chk({asol, aeol, aeof} == {x == 0, x == c.dw - 1, (x == c.dw - 1) && (y == c.dh - 1)},
        "R5", {ch, " sol/eol/eof"}, int'({asol, aeol, aeof}),
        int'({x == 0, x == c.dw - 1, (x == c.dw - 1) && (y == c.dh - 1)}));
  endtask

  task automatic run_frame(input int k);
    axcfg_t lc = LV[k];
    axcfg_t cc = CV[k];
    int lx = 0, ly = 0, cx = 0, cy = 0, lbeats = 0, cbeats = 0, cyc = 0;
    bit ldone = 0, cdone = 0, lst = 0, cst = 0;
    bit long_frame = (lc.dw * lc.dh > 8) && (cc.dw * cc.dh > 8);
    logic [34:0] lsave = '0, csave = '0;
    l_src_res = pack_res(lc.sw, lc.sh);  l_dst_res = pack_res(lc.dw, lc.dh);
    l_hstart = lc.hs;  l_vstart = lc.vs;
    l_hinc = 16'(rinc(lc.sw, lc.dw));  l_vinc = 16'(rinc(lc.sh, lc.dh));
    c_src_res = pack_res(cc.sw, cc.sh);  c_dst_res = pack_res(cc.dw, cc.dh);
    c_hstart = cc.hs;  c_vstart = cc.vs;
    c_hinc = 16'(rinc(cc.sw, cc.dw));  c_vinc = 16'(rinc(cc.sh, cc.dh));
    frame_go = 1'b1;
    @(negedge clk);
    chk(l_vld && c_vld, "R1", "valid after frame_go", int'({l_vld, c_vld}), 3);
    while (!(ldone && cdone) && cyc < 5000) begin
      // R9: a go pulse in mid frame must be ignored
      frame_go = (cyc == 3) && long_frame;
      l_rdy = (cyc % 3) != 2;
      c_rdy = (cyc % 4) != 0;
      if (lst) chk(lsave == {l_x_idx, l_x_ph, l_y_idx, l_y_ph, l_sol, l_eol, l_eof},
                   "R2", "luma hold under stall", 0, 0);
      if (cst) chk(csave == {c_x_idx, c_x_ph, c_y_idx, c_y_ph, c_sol, c_eol, c_eof},
                   "R2", "chroma hold under stall", 0, 0);
      lst = l_vld && !l_rdy;
      cst = c_vld && !c_rdy;
      lsave = {l_x_idx, l_x_ph, l_y_idx, l_y_ph, l_sol, l_eol, l_eof};
      csave = {c_x_idx, c_x_ph, c_y_idx, c_y_ph, c_sol, c_eol, c_eof};
      if (l_vld && l_rdy && !ldone) begin
        beat("luma", lc, lx, ly, l_x_idx, l_x_ph, l_y_idx, l_y_ph, l_sol, l_eol, l_eof);
        lbeats++;
        if (l_eof) ldone = 1;
        if (lx == lc.dw - 1) begin lx = 0; ly++; end else lx++;
      end
      if (c_vld && c_rdy && !cdone) begin
        beat("chroma", cc, cx, cy, c_x_idx, c_x_ph, c_y_idx, c_y_ph, c_sol, c_eol, c_eof);
        cbeats++;
        if (c_eof) cdone = 1;
        if (cx == cc.dw - 1) begin cx = 0; cy++; end else cx++;
      end
      @(negedge clk);
      cyc++;
    end
    frame_go = 1'b0;
    l_rdy = 1'b1;
    c_rdy = 1'b1;
    chk(cyc < 5000, "R5", "frame completes", cyc, 5000);
    chk(lbeats == lc.dw * lc.dh, "R5", "luma beat count", lbeats, lc.dw * lc.dh);
    chk(cbeats == cc.dw * cc.dh, "R8", "chroma beat count", cbeats, cc.dw * cc.dh);
    chk(!l_vld && !c_vld, "R5", "valid low after frame end", int'({l_vld, c_vld}), 0);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;  frame_go = 1'b0;  l_rdy = 1'b1;  c_rdy = 1'b1;
    l_src_res = '0; l_dst_res = '0; c_src_res = '0; c_dst_res = '0;
    l_hstart = '0; c_hstart = '0; l_vstart = '0; c_vstart = '0;
    l_hinc = '0; l_vinc = '0; c_hinc = '0; c_vinc = '0;
    repeat (3) @(negedge clk);
    chk(!l_vld && !c_vld, "R1", "valid during reset", int'({l_vld, c_vld}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!l_vld && !c_vld, "R1", "valid idle without go", int'({l_vld, c_vld}), 0);
    for (int k = 0; k < NVEC; k++) run_frame(k);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule